// File: doc/BRIEF.md
# Configurable Wide AND Decoder

This block is a wide AND gate whose inputs can each be programmed. It sits along one edge of a programmable logic array. It takes a flat vector of up to 72 literal sources, made up of edge I/O signals and local signals, with up to three coming from each row or column of cells. For every source, a stored 2-bit selector decides how it enters the product:

- it is left out,
- it is used as is,
- it is inverted, or
- it forces the product false.

The result behaves like one product term of a PAL-style AND plane.

A mode register lets the decoder split at runtime into two independent half-width decoders. In split mode the lower half of the sources feeds output bit 0 and the upper half feeds output bit 1. When the decoder is not split, both output bits carry the full-width product.

An output register is also provided. It loads the live result on a rising clock edge whenever sampling is enabled. A second mode bit chooses whether the ports show the live result or the held one.

Selectors are written one source at a time through a small write port. Both mode bits are written together through a second write port.

Top module: `edge_and_decoder`

## Requirements
- R1: While reset is active and directly after it, every selector holds code 00, both mode bits are 0 and the output register holds 2'b00, so `dec_out` reads 2'b11.
- R2: A source whose selector is 2'b01 lets its product be true only when that source is 1.
- R3: A source whose selector is 2'b10 lets its product be true only when that source is 0.
- R4: A source whose selector is 2'b11 forces its product false whatever the source value, in both split and unsplit mode.
- R5: A product all of whose selectors are 2'b00 is true regardless of the sources.
- R6: With `split` at 0, both output bits carry the AND over all N_IN sources.
- R7: With `split` at 1, output bit 0 is the AND over sources 0 to N_IN/2-1 and output bit 1 is the AND over sources N_IN/2 to N_IN-1. Sources N_IN/2-1 and N_IN/2 are the boundary between the halves.
- R8: A selector write with `cfg_we` high stores `cfg_code` for source `cfg_sel` from the next cycle on. A write whose `cfg_sel` is N_IN or larger changes no selector.
- R9: With the registered mode bit at 1, `dec_out` shows a register that loads the live result at a rising edge where `smp_en` is 1 and holds otherwise. Its reset value is 2'b00.
- R10: A mode write with `mode_we` high sets `split` from `mode_split` and the registered mode bit from `mode_reg`, and both take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Selector write strobe |
| cfg_sel | input | $clog2(N_IN) | Index of the source whose selector is written |
| cfg_code | input | 2 | Selector value: 00 skip, 01 true, 10 inverted, 11 force false |
| mode_we | input | 1 | Mode write strobe |
| mode_split | input | 1 | Value for the split mode bit |
| mode_reg | input | 1 | Value for the registered-output mode bit |
| smp_en | input | 1 | Output register load enable |
| lits | input | N_IN | Literal sources, edge I/O and local signals |
| dec_out | output | 2 | Decoder result; one bit per half when split, both equal otherwise |

## Verification
The bench targets the two sources on either side of the split point. A design that places that boundary one position off would let a value on the wrong side decide the other half's output. It places a force-false selector in one half while split, so that any leakage into the other half shows on the output that should have stayed live. It also writes selectors at index N_IN and at the largest index the select field can hold; a design that wraps or truncates the index would silently kill a real source. In registered mode, `smp_en` is toggled while the sources keep changing, so a register that follows the live result without waiting for `smp_en` would show up at once.

// File: rtl/edec_pkg.sv
package edec_pkg;

    typedef enum logic [1:0] {
        LIT_SKIP = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_INV  = 2'b10,
        LIT_KILL = 2'b11
    } lit_sel_e;

    typedef struct packed {
        logic split;
        logic regd;
    } dec_mode_t;

    // Contribution of one source to its product term.
    function automatic logic lit_pass(input logic [1:0] sel, input logic v);
        lit_sel_e s;
        s = lit_sel_e'(sel);
        case (s)
            LIT_SKIP: return 1'b1;
            LIT_TRUE: return v;
            LIT_INV:  return !v;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/edec_cfg_store.sv
module edec_cfg_store
    import edec_pkg::*;
#(
    parameter int N_IN = 72,
    localparam int SEL_W = $clog2(N_IN),
    localparam int CODE_W = 2 * N_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [1:0]        cfg_code,
    input  logic              mode_we,
    input  logic              mode_split,
    input  logic              mode_reg,
    output logic [CODE_W-1:0] codes_o,
    output dec_mode_t         mode_o
);

    typedef struct packed {
        logic [CODE_W-1:0] codes;
        dec_mode_t         mode;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            // Indices at or above N_IN match no entry and are dropped.
            for (int i = 0; i < N_IN; i++) begin
                if (cfg_sel == SEL_W'(i)) begin
                    st_d.codes[2*i +: 2] = cfg_code;
                end
            end
        end
        if (mode_we) begin
            st_d.mode.split = mode_split;
            st_d.mode.regd  = mode_reg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign codes_o = st_q.codes;
    assign mode_o  = st_q.mode;

endmodule

// File: rtl/edec_terms.sv
module edec_terms
    import edec_pkg::*;
#(
    parameter int N_IN = 72,
    localparam int HALF = N_IN / 2,
    localparam int CODE_W = 2 * N_IN
) (
    input  logic [N_IN-1:0]   lits,
    input  logic [CODE_W-1:0] codes,
    output logic              lo_hit,
    output logic              hi_hit
);

    logic [N_IN-1:0] pass;

    for (genvar g = 0; g < N_IN; g++) begin : g_lit
        assign pass[g] = lit_pass(codes[2*g +: 2], lits[g]);
    end

    assign lo_hit = &pass[HALF-1:0];
    assign hi_hit = &pass[N_IN-1:HALF];

endmodule

// File: rtl/edec_out_stage.sv
module edec_out_stage
    import edec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_en,
    input  logic       lo_hit,
    input  logic       hi_hit,
    input  dec_mode_t  mode,
    output logic [1:0] dec_out
);

    typedef struct packed {
        logic [1:0] held;
    } out_state_t;

    out_state_t st_d, st_q;
    logic [1:0] live;

    always_comb begin
        if (mode.split) begin
            live = {hi_hit, lo_hit};
        end else begin
            live = {2{lo_hit & hi_hit}};
        end
        st_d = st_q;
        if (smp_en) begin
            st_d.held = live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_out = mode.regd ? st_q.held : live;

endmodule

// File: rtl/edge_and_decoder.sv
module edge_and_decoder
    import edec_pkg::*;
#(
    parameter int N_IN = 72,
    localparam int SEL_W = $clog2(N_IN),
    localparam int CODE_W = 2 * N_IN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [1:0]       cfg_code,
    input  logic             mode_we,
    input  logic             mode_split,
    input  logic             mode_reg,
    input  logic             smp_en,
    input  logic [N_IN-1:0]  lits,
    output logic [1:0]       dec_out
);

    logic [CODE_W-1:0] codes_flat;
    dec_mode_t         mode_q;
    logic              split_q;
    logic              reg_q;
    logic              lo_hit;
    logic              hi_hit;

    edec_cfg_store #(.N_IN(N_IN)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_code   (cfg_code),
        .mode_we    (mode_we),
        .mode_split (mode_split),
        .mode_reg   (mode_reg),
        .codes_o    (codes_flat),
        .mode_o     (mode_q)
    );

    edec_terms #(.N_IN(N_IN)) u_terms (
        .lits   (lits),
        .codes  (codes_flat),
        .lo_hit (lo_hit),
        .hi_hit (hi_hit)
    );

    edec_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .mode    (mode_q),
        .dec_out (dec_out)
    );

    assign split_q = mode_q.split;
    assign reg_q   = mode_q.regd;

endmodule

// File: rtl/edge_and_decoder_chk.sv
module edge_and_decoder_chk #(
    parameter int N_IN = 72,
    localparam int HALF = N_IN / 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_en,
    input logic                split_q,
    input logic                reg_q,
    input logic [2*N_IN-1:0]   codes,
    input logic [1:0]          dec_out
);

    logic kill_lo;
    logic kill_hi;

    always_comb begin
        kill_lo = 1'b0;
        kill_hi = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (codes[2*i +: 2] == 2'b11) begin
                if (i < HALF) kill_lo = 1'b1;
                else          kill_hi = 1'b1;
            end
        end
    end

    // R4: a force-false selector in the lower half clears output bit 0
    p_kill_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q && kill_lo) |-> (dec_out[0] == 1'b0));

    // R4: a force-false selector in the upper half clears output bit 1
    p_kill_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q && kill_hi) |-> (dec_out[1] == 1'b0));

    // R5: all selectors skipped gives a true product
    p_all_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q && (codes == '0)) |-> (dec_out == 2'b11));

    // R6: unsplit live outputs agree
    p_unsplit_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q && !split_q) |-> (dec_out[0] == dec_out[1]));

    // R9: held output does not move without a sample
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q && !smp_en) |=> (!reg_q || $stable(dec_out)));

endmodule

bind edge_and_decoder edge_and_decoder_chk #(.N_IN(N_IN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_en  (smp_en),
    .split_q (split_q),
    .reg_q   (reg_q),
    .codes   (codes_flat),
    .dec_out (dec_out)
);

// File: tb/edge_and_decoder_bench.sv
`timescale 1ns/1ps
module edge_and_decoder_bench;

    localparam int N = 72;
    localparam int H = N / 2;
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [SW-1:0] cfg_sel;
    logic [1:0]    cfg_code;
    logic          mode_we;
    logic          mode_split;
    logic          mode_reg;
    logic          smp_en;
    logic [N-1:0]  lits;
    logic [1:0]    dec_out;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // reference model state
    int         code_m [N];
    bit         split_m;
    bit         reg_m;
    logic [1:0] oreg_m;

    always #2.5 clk = ~clk;

    edge_and_decoder #(.N_IN(N)) u_edge_and_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_code   (cfg_code),
        .mode_we    (mode_we),
        .mode_split (mode_split),
        .mode_reg   (mode_reg),
        .smp_en     (smp_en),
        .lits       (lits),
        .dec_out    (dec_out)
    );

    function automatic logic [1:0] model_live(logic [N-1:0] v);
        bit lo = 1'b1;
        bit hi = 1'b1;
        for (int i = 0; i < N; i++) begin
            bit p;
            case (code_m[i])
                0:       p = 1'b1;
                1:       p = v[i];
                2:       p = !v[i];
                default: p = 1'b0;
            endcase
            if (i < H) lo = lo & p;
            else       hi = hi & p;
        end
        return split_m ? {hi, lo} : {lo & hi, lo & hi};
    endfunction

    function automatic logic [1:0] model_out();
        return reg_m ? oreg_m : model_live(lits);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) code_m[i] = 0;
        split_m = 1'b0;
        reg_m   = 1'b0;
        oreg_m  = 2'b00;
    endtask

    task automatic model_edge();
        logic [1:0] live_now;
        live_now = model_live(lits);
        if (smp_en) oreg_m = live_now;
        if (cfg_we && int'(cfg_sel) < N) code_m[int'(cfg_sel)] = int'(cfg_code);
        if (mode_we) begin
            split_m = mode_split;
            reg_m   = mode_reg;
        end
    endtask

    task automatic compare();
        logic [1:0] exp_v;
        exp_v = model_out();
        checks++;
        if (dec_out !== exp_v) begin
            fails++;
            $display("FAIL %s: dec_out actual=%b expected=%b at %0t", cur_req, dec_out, exp_v, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr_code(int idx, int code);
        cfg_we   = 1'b1;
        cfg_sel  = SW'(idx);
        cfg_code = 2'(code);
        tick();
        cfg_we   = 1'b0;
    endtask

    task automatic wr_mode(bit s, bit r);
        mode_we    = 1'b1;
        mode_split = s;
        mode_reg   = r;
        tick();
        mode_we    = 1'b0;
    endtask

    function automatic logic [N-1:0] gen_lits();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            case (code_m[i])
                1:       v[i] = 1'b1;
                2:       v[i] = 1'b0;
                default: v[i] = 1'($urandom);
            endcase
        end
        if (($urandom % 2) == 0) begin
            int k;
            k = int'($urandom % N);
            v[k] = ~v[k];
        end
        return v;
    endfunction

    task automatic run(int n);
        for (int c = 0; c < n; c++) begin
            lits   = gen_lits();
            smp_en = 1'($urandom);
            tick();
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run actual=unfinished expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_code = '0;
        mode_we = 1'b0; mode_split = 1'b0; mode_reg = 1'b0; smp_en = 1'b0;
        lits = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        compare();                        // R1: state after reset
        lits = '1;
        tick();

        cur_req = "R5";
        run(20);

        cur_req = "R2";
        wr_code(0, 1); wr_code(35, 1); wr_code(71, 1);
        run(40);

        cur_req = "R3";
        wr_code(36, 2); wr_code(5, 2);
        run(40);

        cur_req = "R4";
        wr_code(10, 3);
        run(15);
        wr_code(10, 0);
        run(10);

        cur_req = "R6";
        run(20);

        cur_req = "R10";
        wr_mode(1'b1, 1'b0);

        cur_req = "R7";
        run(40);
        wr_code(20, 3);
        run(20);
        wr_code(20, 0);
        wr_code(50, 3);
        run(20);
        wr_code(50, 0);
        wr_code(35, 2); wr_code(36, 1);   // boundary sources
        run(40);

        cur_req = "R8";
        wr_code(72, 3);
        wr_code(127, 3);
        run(30);

        cur_req = "R9";
        wr_mode(1'b0, 1'b1);
        run(60);

        cur_req = "R10";
        wr_mode(1'b1, 1'b1);
        run(30);
        wr_mode(1'b0, 1'b0);
        run(20);

        summary();
        $finish;
    end

endmodule